// File: doc/BRIEF.md
# Two-Thread Core Idle-State Resolver

This block follows the idle request of each hardware thread in a multi-thread core and folds them into one core idle level. A thread that is executing may ask for one of three idle levels (light halt, halt with low voltage/frequency, or deep power-down). It may qualify the request as a monitor wait, as a timed wait with a deadline, or as both. Each idle thread returns to the executing level on its own wake event: an interrupt aimed at it, a hit on the monitored address when it armed a monitor, or the expiry of its deadline when it asked for a timed wait.

The resolved core level is the shallowest of the thread levels. From it the block drives clock gating and a low voltage/frequency request. When the core as a whole settles in the deep level, a sequencer runs cache flush, state save, power-down and clock-off in that order. Each of these steps uses a request/acknowledge handshake with logic outside the block. A wake during the deep sequence either cancels it or, once power-down has begun, leads through a restore handshake.

Top module: `core_idle_resolver`

## Requirements
- R1: Level codes are 0 = executing, 1 = halt, 2 = halt with low V/F, 3 = deep. `core_state` equals the smallest of the per-thread codes in `thread_state`, where thread i occupies bits [2i+1:2i].
- R2: While any thread is at code 0, `core_state` is 0.
- R3: A request (`req_valid[i]` with a nonzero `req_state` code) is taken only from a thread at code 0, and shows in `thread_state` after the next clock edge. A request to a thread that is already idle has no effect.
- R4: `irq[i]` returns thread i to code 0 at the next edge and pulses `wake[i]` for one cycle. It leaves every other thread unchanged.
- R5: `mon_hit` wakes only those idle threads whose request had `req_monitor` set.
- R6: A thread that entered with `req_timed` set loads `req_deadline` as D and returns to code 0 at the D+1st edge after the entry edge. Without `req_timed`, the deadline has no effect.
- R7: `clk_gate` is high whenever `core_state` is nonzero. `lowvf_req` is high exactly when `core_state` is 2.
- R8: One edge after `core_state` becomes 3, `flush_req` rises and holds until `flush_done`. Then `save_req` holds until `save_done`. Then `pwr_down` is high for one cycle alone, and after that `pwr_down` and `core_clk_off` are high together.
- R9: If `core_state` leaves 3 while `flush_req` or `save_req` is high, the sequence drops both requests at the next edge without raising `pwr_down`.
- R10: If `core_state` leaves 3 during power-down or clock-off, `restore_req` rises at the next edge with `pwr_down` and `core_clk_off` low. It holds until `restore_done`.
- R11: A low `rst_n` at a clock edge puts every thread at code 0, clears monitor and deadline conditions, and puts the sequencer at rest with every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NT | Per-thread idle request strobe |
| req_state | input | 2*NT | Requested level code per thread |
| req_monitor | input | NT | Request arms the monitor wake |
| req_timed | input | NT | Request arms the deadline wake |
| req_deadline | input | DW*NT | Deadline count per thread |
| irq | input | NT | Per-thread interrupt |
| mon_hit | input | 1 | Write seen on the monitored address |
| flush_done | input | 1 | Cache flush acknowledge |
| save_done | input | 1 | State save acknowledge |
| restore_done | input | 1 | State restore acknowledge |
| thread_state | output | 2*NT | Current level code per thread |
| wake | output | NT | One-cycle wake pulse per thread |
| core_state | output | 2 | Resolved core level code |
| clk_gate | output | 1 | Core clock gating enable |
| lowvf_req | output | 1 | Lowest V/F operating point request |
| flush_req | output | 1 | Cache flush request |
| save_req | output | 1 | State save request |
| pwr_down | output | 1 | Core voltage reduction |
| core_clk_off | output | 1 | Core clocks stopped |
| restore_req | output | 1 | State restore request |

## Verification
Thread levels and wake pulses are registered, so they change at the first edge after a request or wake event. The bench drives stimulus just after an edge, advances one edge, and reads the result 1 ns later. `core_state`, `clk_gate` and `lowvf_req` follow combinationally from the thread levels and are read in that same window. Every deep-sequence output lags `core_state` or an acknowledge by one more edge, so the bench advances one further edge before it checks those. The deadline sweep counts edges from the entry edge until the thread reads 0 and compares the count with D+1.

// File: rtl/cidle_pkg.sv
// Package: shared level codes and deep-sequence states for the idle resolver.
// Assumes lower code = shallower level, so a minimum picks the core level.
package cidle_pkg;
    localparam int LVL_W = 2;

    typedef enum logic [1:0] {
        LV_RUN  = 2'd0,
        LV_HALT = 2'd1,
        LV_LOW  = 2'd2,
        LV_DEEP = 2'd3
    } level_e;

    typedef enum logic [2:0] {
        DS_IDLE    = 3'd0,
        DS_FLUSH   = 3'd1,
        DS_SAVE    = 3'd2,
        DS_PWRDN   = 3'd3,
        DS_OFF     = 3'd4,
        DS_RESTORE = 3'd5
    } dseq_e;
endpackage

// File: rtl/cidle_thread.sv
// Module: per-thread idle tracker. It holds one thread's level, the wait
// qualifiers captured at entry, and the deadline down counter.
// Assumes: requests are honoured only while the thread executes; any wake
// source returns the thread to the executing level at the next edge.
module cidle_thread
    import cidle_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LVL_W-1:0] req_state,
    input  logic             req_monitor,
    input  logic             req_timed,
    input  logic [DW-1:0]    req_deadline,
    input  logic             irq,
    input  logic             mon_hit,
    output logic [LVL_W-1:0] level_o,
    output logic             wake_o
);
    level_e        lvl_q;
    logic          mon_armed_q;
    logic          timed_q;
    logic [DW-1:0] cnt_q;
    logic          wake_q;
    logic          wake_now;
    logic          take_req;

    // Purpose: collect the wake sources that apply to how the thread entered.
    always_comb begin
        wake_now = irq
                 | (mon_armed_q & mon_hit)
                 | (timed_q & (cnt_q == '0));
    end

    // Purpose: accept an idle request only from the executing level.
    always_comb begin
        take_req = req_valid && (lvl_q == LV_RUN) && (req_state != LV_RUN);
    end

    // Purpose: level, qualifiers, deadline counter and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q       <= LV_RUN;
            mon_armed_q <= 1'b0;
            timed_q     <= 1'b0;
            cnt_q       <= '0;
            wake_q      <= 1'b0;
        end else begin
            wake_q <= 1'b0;
            if (lvl_q == LV_RUN) begin
                if (take_req) begin
                    lvl_q       <= level_e'(req_state);
                    mon_armed_q <= req_monitor;
                    timed_q     <= req_timed;
                    cnt_q       <= req_deadline;
                end
            end else if (wake_now) begin
                lvl_q       <= LV_RUN;
                mon_armed_q <= 1'b0;
                timed_q     <= 1'b0;
                wake_q      <= 1'b1;
            end else if (timed_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign level_o = lvl_q;
    assign wake_o  = wake_q;
endmodule

// File: rtl/cidle_min.sv
// Module: resolves the core level as the smallest of NT thread level codes.
// Assumes: codes are ordered shallow to deep; purely combinational.
module cidle_min
    import cidle_pkg::*;
#(
    parameter int NT = 2
) (
    input  logic [NT*LVL_W-1:0] levels,
    output logic [LVL_W-1:0]    core_lvl
);
    // Purpose: running minimum over all thread codes.
    always_comb begin
        core_lvl = LV_DEEP;
        for (int i = 0; i < NT; i++) begin
            if (levels[i*LVL_W +: LVL_W] < core_lvl) begin
                core_lvl = levels[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/cidle_deep_seq.sv
// Module: deep-level entry and exit sequencer. In order: flush, save,
// power-down and clock-off. Flush, save and restore are handshakes with
// external logic.
// Assumes: a core level below deep while flushing or saving cancels the
// entry; once power-down has begun, exit goes through restore.
module cidle_deep_seq
    import cidle_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] core_lvl,
    input  logic             flush_done,
    input  logic             save_done,
    input  logic             restore_done,
    output logic             flush_req,
    output logic             save_req,
    output logic             pwr_down,
    output logic             core_clk_off,
    output logic             restore_req
);
    dseq_e st_q, st_d;
    logic  deep;

    assign deep = (core_lvl == LV_DEEP);

    // Purpose: next-state selection for the deep sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DS_IDLE:    if (deep) st_d = DS_FLUSH;
            DS_FLUSH:   if (!deep) st_d = DS_IDLE;
                        else if (flush_done) st_d = DS_SAVE;
            DS_SAVE:    if (!deep) st_d = DS_IDLE;
                        else if (save_done) st_d = DS_PWRDN;
            DS_PWRDN:   if (!deep) st_d = DS_RESTORE;
                        else st_d = DS_OFF;
            DS_OFF:     if (!deep) st_d = DS_RESTORE;
            DS_RESTORE: if (restore_done) st_d = DS_IDLE;
            default:    st_d = DS_IDLE;
        endcase
    end

    // Purpose: sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DS_IDLE;
        else        st_q <= st_d;
    end

    // Purpose: decode handshake and power outputs from the state.
    always_comb begin
        flush_req    = (st_q == DS_FLUSH);
        save_req     = (st_q == DS_SAVE);
        pwr_down     = (st_q == DS_PWRDN) || (st_q == DS_OFF);
        core_clk_off = (st_q == DS_OFF);
        restore_req  = (st_q == DS_RESTORE);
    end
endmodule

// File: rtl/core_idle_resolver.sv
// Module: top of the idle resolver. NT thread trackers feed a minimum
// resolver; the resolved level drives clock gating, the low V/F request and
// the deep sequencer.
// Assumes: synchronous active-low reset; the flush, save and restore
// partners answer with single-cycle or held acknowledges.
module core_idle_resolver
    import cidle_pkg::*;
#(
    parameter int NT = 2,
    parameter int DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT-1:0]       req_valid,
    input  logic [NT*LVL_W-1:0] req_state,
    input  logic [NT-1:0]       req_monitor,
    input  logic [NT-1:0]       req_timed,
    input  logic [NT*DW-1:0]    req_deadline,
    input  logic [NT-1:0]       irq,
    input  logic                mon_hit,
    input  logic                flush_done,
    input  logic                save_done,
    input  logic                restore_done,
    output logic [NT*LVL_W-1:0] thread_state,
    output logic [NT-1:0]       wake,
    output logic [LVL_W-1:0]    core_state,
    output logic                clk_gate,
    output logic                lowvf_req,
    output logic                flush_req,
    output logic                save_req,
    output logic                pwr_down,
    output logic                core_clk_off,
    output logic                restore_req
);
    logic [LVL_W-1:0] core_lvl;

    // Purpose: one tracker per hardware thread.
    for (genvar g = 0; g < NT; g++) begin : g_thr
        cidle_thread #(.DW(DW)) u_thr (
            .clk          (clk),
            .rst_n        (rst_n),
            .req_valid    (req_valid[g]),
            .req_state    (req_state[g*LVL_W +: LVL_W]),
            .req_monitor  (req_monitor[g]),
            .req_timed    (req_timed[g]),
            .req_deadline (req_deadline[g*DW +: DW]),
            .irq          (irq[g]),
            .mon_hit      (mon_hit),
            .level_o      (thread_state[g*LVL_W +: LVL_W]),
            .wake_o       (wake[g])
        );
    end

    cidle_min #(.NT(NT)) u_min (
        .levels   (thread_state),
        .core_lvl (core_lvl)
    );

    cidle_deep_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_lvl     (core_lvl),
        .flush_done   (flush_done),
        .save_done    (save_done),
        .restore_done (restore_done),
        .flush_req    (flush_req),
        .save_req     (save_req),
        .pwr_down     (pwr_down),
        .core_clk_off (core_clk_off),
        .restore_req  (restore_req)
    );

    // Purpose: core-level clock gating and V/F request from the resolved level.
    always_comb begin
        core_state = core_lvl;
        clk_gate   = (core_lvl != LV_RUN);
        lowvf_req  = (core_lvl == LV_LOW);
    end
endmodule

// File: rtl/cidle_checker.sv
// Module: assertion checker attached to core_idle_resolver by bind.
// Assumes: same parameters as the bound instance.
module cidle_checker #(
    parameter int NT = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NT*2-1:0] thread_state,
    input logic [NT-1:0]   irq,
    input logic [1:0]      core_state,
    input logic            flush_req,
    input logic            flush_done,
    input logic            save_req,
    input logic            pwr_down,
    input logic            core_clk_off,
    input logic            restore_req
);
    for (genvar g = 0; g < NT; g++) begin : g_chk
        // R1: core level never deeper than any thread level
        a_r1_core_not_deeper: assert property (@(posedge clk) disable iff (!rst_n)
            core_state <= thread_state[g*2 +: 2]);
        // R2: an executing thread forces the core to execute
        a_r2_run_dominates: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_state[g*2 +: 2] == 2'd0) |-> (core_state == 2'd0));
        // R4: an interrupt returns an idle thread at the next edge
        a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && thread_state[g*2 +: 2] != 2'd0) |=> (thread_state[g*2 +: 2] == 2'd0));
    end

    // R8: save request begins only after an acknowledged flush
    a_r8_save_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_req) |-> $past(flush_req && flush_done));
    // R8: clock-off is reached only through power-down
    a_r8_off_after_pwrdn: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_off) |-> $past(pwr_down));
    // R9: leaving the deep level during flush cancels it without power-down
    a_r9_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && core_state != 2'd3) |=> (!flush_req && !save_req && !pwr_down));
    // R10: restore follows only power-down or clock-off
    a_r10_restore_from_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_req) |-> $past(pwr_down));
endmodule

bind core_idle_resolver cidle_checker #(.NT(NT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .thread_state (thread_state),
    .irq          (irq),
    .core_state   (core_state),
    .flush_req    (flush_req),
    .flush_done   (flush_done),
    .save_req     (save_req),
    .pwr_down     (pwr_down),
    .core_clk_off (core_clk_off),
    .restore_req  (restore_req)
);

// File: tb/core_idle_resolver_tb.sv
`timescale 1ns/1ps
module core_idle_resolver_tb;
    localparam int NT = 2;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NT-1:0]   req_valid;
    logic [NT*2-1:0] req_state;
    logic [NT-1:0]   req_monitor;
    logic [NT-1:0]   req_timed;
    logic [NT*DW-1:0] req_deadline;
    logic [NT-1:0]   irq;
    logic            mon_hit, flush_done, save_done, restore_done;
    logic [NT*2-1:0] thread_state;
    logic [NT-1:0]   wake;
    logic [1:0]      core_state;
    logic clk_gate, lowvf_req, flush_req, save_req, pwr_down, core_clk_off, restore_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    core_idle_resolver #(.NT(NT), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
        .req_monitor(req_monitor), .req_timed(req_timed), .req_deadline(req_deadline),
        .irq(irq), .mon_hit(mon_hit), .flush_done(flush_done), .save_done(save_done),
        .restore_done(restore_done), .thread_state(thread_state), .wake(wake),
        .core_state(core_state), .clk_gate(clk_gate), .lowvf_req(lowvf_req),
        .flush_req(flush_req), .save_req(save_req), .pwr_down(pwr_down),
        .core_clk_off(core_clk_off), .restore_req(restore_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_req(input int t, input int st, input bit mon, input bit tm, input int dl);
        req_valid[t]             = 1'b1;
        req_state[t*2 +: 2]      = st[1:0];
        req_monitor[t]           = mon;
        req_timed[t]             = tm;
        req_deadline[t*DW +: DW] = dl;
    endtask

    task automatic clr_in();
        req_valid = '0; req_state = '0; req_monitor = '0; req_timed = '0;
        req_deadline = '0; irq = '0; mon_hit = 1'b0;
        flush_done = 1'b0; save_done = 1'b0; restore_done = 1'b0;
    endtask

    function automatic int lvl(input int t);
        return int'(thread_state[t*2 +: 2]);
    endfunction

    task automatic seq_quiet(input string tag);
        chk(tag, {flush_req, save_req, pwr_down, core_clk_off, restore_req}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clr_in();
        rst_n = 1'b0;
        tick(); tick();
        // R11: reset state
        chk("R11 thread_state", int'(thread_state), 0);
        chk("R11 core_state", int'(core_state), 0);
        seq_quiet("R11 seq outputs");
        rst_n = 1'b1;
        tick();

        // R1 R2 R7: sweep of all level pairs
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                int m;
                m = (a < b) ? a : b;
                set_req(0, a, 1'b0, 1'b0, 0);
                set_req(1, b, 1'b0, 1'b0, 0);
                tick();
                clr_in();
                chk($sformatf("R3 t0 level pair %0d/%0d", a, b), lvl(0), a);
                chk($sformatf("R1 core pair %0d/%0d", a, b), int'(core_state), m);
                if (a == 0 || b == 0) chk("R2 run dominates", int'(core_state), 0);
                chk("R7 clk_gate", int'(clk_gate), (m != 0) ? 1 : 0);
                chk("R7 lowvf_req", int'(lowvf_req), (m == 2) ? 1 : 0);
                irq = 2'b11;
                tick();
                clr_in();
                chk("R4 both woken", int'(thread_state), 0);
                chk("R4 wake pulse", int'(wake), ((a != 0) ? 1 : 0) | ((b != 0) ? 2 : 0));
                tick(); tick();
                chk("R4 wake one cycle", int'(wake), 0);
                seq_quiet("R9 sweep leaves sequencer at rest");
            end
        end

        // R4: interrupt aimed at one thread only
        set_req(0, 1, 1'b0, 1'b0, 0);
        set_req(1, 1, 1'b0, 1'b0, 0);
        tick(); clr_in();
        irq = 2'b01;
        tick(); clr_in();
        chk("R4 target woken", lvl(0), 0);
        chk("R4 other untouched", lvl(1), 1);
        chk("R2 core runs", int'(core_state), 0);
        // R3: request to idle thread ignored
        set_req(1, 3, 1'b0, 1'b0, 0);
        tick(); clr_in();
        chk("R3 idle request ignored", lvl(1), 1);
        irq = 2'b10; tick(); clr_in();

        // R5: monitor hit wakes only armed thread
        set_req(0, 2, 1'b1, 1'b0, 0);
        set_req(1, 2, 1'b0, 1'b0, 0);
        tick(); clr_in();
        mon_hit = 1'b1;
        tick(); clr_in();
        chk("R5 armed woken", lvl(0), 0);
        chk("R5 unarmed stays", lvl(1), 2);
        irq = 2'b10; tick(); clr_in();

        // R6: deadline sweep
        for (int d = 0; d < 6; d++) begin
            int n;
            n = 0;
            set_req(0, 2, 1'b0, 1'b1, d);
            tick(); clr_in();
            while (lvl(0) != 0 && n < 50) begin
                tick();
                n++;
            end
            chk($sformatf("R6 timed wake edges D=%0d", d), n, d + 1);
        end
        // R6: untimed ignores deadline
        set_req(0, 1, 1'b0, 1'b0, 0);
        tick(); clr_in();
        repeat (10) tick();
        chk("R6 untimed stays idle", lvl(0), 1);
        irq = 2'b01; tick(); clr_in();

        // R8 R10: full deep sequence and restore
        set_req(0, 3, 1'b0, 1'b0, 0);
        set_req(1, 3, 1'b0, 1'b0, 0);
        tick(); clr_in();
        chk("R8 seq not yet started", int'(flush_req), 0);
        tick();
        chk("R8 flush_req", int'(flush_req), 1);
        tick(); tick();
        chk("R8 flush_req holds", int'(flush_req), 1);
        flush_done = 1'b1; tick(); clr_in();
        chk("R8 save_req", int'({flush_req, save_req}), 1);
        save_done = 1'b1; tick(); clr_in();
        chk("R8 pwr_down alone", int'({pwr_down, core_clk_off, save_req}), 4);
        tick();
        chk("R8 pwr_down and clk_off", int'({pwr_down, core_clk_off}), 3);
        tick();
        chk("R8 off holds", int'({pwr_down, core_clk_off}), 3);
        irq = 2'b01; tick(); clr_in();
        chk("R10 core exits deep", int'(core_state), 0);
        tick();
        chk("R10 restore_req", int'({restore_req, pwr_down, core_clk_off}), 4);
        tick();
        chk("R10 restore holds", int'(restore_req), 1);
        restore_done = 1'b1; tick(); clr_in();
        chk("R10 restore done", int'(restore_req), 0);
        irq = 2'b10; tick(); clr_in();

        // R9: abort during save
        set_req(0, 3, 1'b0, 1'b0, 0);
        set_req(1, 3, 1'b0, 1'b0, 0);
        tick(); clr_in();
        tick();
        flush_done = 1'b1; tick(); clr_in();
        chk("R9 in save", int'(save_req), 1);
        irq = 2'b10; tick(); clr_in();
        tick();
        seq_quiet("R9 save aborted");
        tick();
        seq_quiet("R9 stays at rest");
        irq = 2'b01; tick(); clr_in();

        // R11: reset from mid-state
        set_req(0, 2, 1'b1, 1'b1, 100);
        set_req(1, 3, 1'b0, 1'b0, 0);
        tick(); clr_in();
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R11 mid reset threads", int'(thread_state), 0);
        seq_quiet("R11 mid reset seq");
        mon_hit = 1'b1; tick(); clr_in();
        chk("R11 monitor cleared", int'(wake), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule